// File: doc/BRIEF.md
# Shared-Adder Priority Sum Selector

This unit forms one of three sums from four unsigned operands using a single physical adder. Two condition bits are resolved in strict priority order. The resolved choice drives two operand multiplexers, and the multiplexers feed the one adder. The three choices are: the sum of the first and second operands, the sum of the first and third operands, or the fourth operand plus one. The mapping is done by steering operands into the adder, not by building three adders and muxing their outputs. The result is available combinationally on `sum_now` in the same evaluation as the inputs.

A one-entry output register with a valid/ready handshake holds a copy of the result. This lets the result be consumed cycle by cycle.

Handshake rules:
- An input beat is accepted on a rising edge when `in_vld` and `in_rdy` are both high.
- `in_rdy` is high whenever the register is empty, or when its contents are being taken in the same cycle (`out_rdy` high).
- While `out_vld` is high and `out_rdy` is low, the register holds its value, `in_rdy` stays low, and offered beats are not captured.

Reset is synchronous and active high.

Top module: `shadd_selector`

## Requirements
- R1: When `sel_first` is 1, `sum_now` equals `opa + opb`.
- R2: When `sel_first` is 0 and `sel_second` is 1, `sum_now` equals `opa + opc`.
- R3: When both condition bits are 0, `sum_now` equals `opd + 1`, with the constant applied as the W-bit value 1.
- R4: `sel_first` takes priority over `sel_second`: with both set, the result is `opa + opb`.
- R5: Every sum wraps modulo 2^W (W = 8 by default), and no carry is presented; for example, 255 + 1 gives 0.
- R6: `sum_now` follows changes of the condition bits and operands with no clock edge in between.
- R7: `in_rdy` equals `!out_vld || out_rdy`. A beat accepted at an edge appears on `out_sum`, with `out_vld` high, right after that edge. The value shown equals `sum_now` as it was at acceptance.
- R8: While `out_vld` is 1 and `out_rdy` is 0, `out_sum` and `out_vld` hold, `in_rdy` is 0, and offered beats are dropped.
- R9: A synchronous reset clears `out_vld` and `out_sum` to 0.
- R10: When the held value is taken and no new beat is accepted at that edge, `out_vld` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input beat offered |
| in_rdy | output | 1 | Output register can take a beat |
| opa | input | W | Operand shared by the first two sums |
| opb | input | W | Second addend for the top-priority sum |
| opc | input | W | Second addend for the middle-priority sum |
| opd | input | W | Operand that is incremented by default |
| sel_first | input | 1 | Top-priority condition |
| sel_second | input | 1 | Second condition |
| sum_now | output | W | Combinational selected sum |
| out_vld | output | 1 | Registered result valid |
| out_rdy | input | 1 | Consumer takes the registered result |
| out_sum | output | W | Registered selected sum |

## Verification
Each condition combination (10, 01, 00 and 11) is driven with the same operand set. This shows whether the right operand pair reaches the adder and whether priority is honoured when both bits are set. Operands at the all-ones limit show whether the sum wraps. Condition bits are also flipped between clock edges, which separates a combinational path from a registered one. The scoreboard runs in phases: with the consumer always ready, with the consumer stalled while new beats are offered, and with the consumer draining. These phases distinguish capture, hold and the drop of `out_vld`, each checked against a model built from three separate adders.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  typedef enum logic [1:0] {
    PICK_AB  = 2'd0,
    PICK_AC  = 2'd1,
    PICK_INC = 2'd2
  } pick_e;
endpackage

// File: rtl/shadd_priority.sv
module shadd_priority
  import shadd_pkg::*;
(
  input  logic  cond_hi,
  input  logic  cond_lo,
  output pick_e pick
);
  always_comb begin
    if (cond_hi)      pick = PICK_AB;
    else if (cond_lo) pick = PICK_AC;
    else              pick = PICK_INC;
  end
endmodule

// File: rtl/shadd_operand_mux.sv
module shadd_operand_mux
  import shadd_pkg::*;
#(
  parameter int W = 8
) (
  input  pick_e        pick,
  input  logic [W-1:0] va,
  input  logic [W-1:0] vb,
  input  logic [W-1:0] vc,
  input  logic [W-1:0] vd,
  output logic [W-1:0] lhs,
  output logic [W-1:0] rhs
);
  localparam logic [W-1:0] STEP = W'(1);

  always_comb begin
    unique case (pick)
      PICK_AB:  begin lhs = va; rhs = vb;   end
      PICK_AC:  begin lhs = va; rhs = vc;   end
      default:  begin lhs = vd; rhs = STEP; end
    endcase
  end
endmodule

// File: rtl/shadd_adder.sv
module shadd_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] total
);
  localparam int WF = W + 1;
  logic [WF-1:0] full;

  assign full  = {1'b0, lhs} + {1'b0, rhs};
  assign total = full[W-1:0];
endmodule

// File: rtl/shadd_out_stage.sv
module shadd_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  output logic         in_rdy,
  input  logic [W-1:0] din,
  output logic         out_vld,
  input  logic         out_rdy,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_rdy   = !vld_q || out_rdy;
  assign take     = in_vld && in_rdy;
  assign out_vld  = vld_q;
  assign out_data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      data_q <= din;
    end else if (out_rdy) begin
      vld_q  <= 1'b0;
    end
  end

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_rdy) |=> (out_vld && out_data == $past(din)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

  p_noready_r8: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |-> !in_rdy);

  p_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (!out_vld && out_data == '0));

  p_drain_r10: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_rdy && !in_vld) |=> !out_vld);
endmodule

// File: rtl/shadd_selector.sv
module shadd_selector
  import shadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  output logic         in_rdy,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opc,
  input  logic [W-1:0] opd,
  input  logic         sel_first,
  input  logic         sel_second,
  output logic [W-1:0] sum_now,
  output logic         out_vld,
  input  logic         out_rdy,
  output logic [W-1:0] out_sum
);
  pick_e        pick;
  logic [W-1:0] lhs, rhs;

  shadd_priority u_prio (
    .cond_hi(sel_first), .cond_lo(sel_second), .pick(pick)
  );

  shadd_operand_mux #(.W(W)) u_mux (
    .pick(pick), .va(opa), .vb(opb), .vc(opc), .vd(opd),
    .lhs(lhs), .rhs(rhs)
  );

  shadd_adder #(.W(W)) u_add (
    .lhs(lhs), .rhs(rhs), .total(sum_now)
  );

  shadd_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy),
    .din(sum_now), .out_vld(out_vld), .out_rdy(out_rdy),
    .out_data(out_sum)
  );

  p_sum_ab_r1: assert property (@(posedge clk) disable iff (rst)
    sel_first |-> sum_now == W'(opa + opb));

  p_sum_ac_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_first && sel_second) |-> sum_now == W'(opa + opc));

  p_sum_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel_first && !sel_second) |-> sum_now == W'(opd + W'(1)));

  p_priority_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_first && sel_second) |-> sum_now != W'(opa + opc) || opb == opc);
endmodule

// File: tb/shadd_selector_tb_top.sv
`timescale 1ns/100ps
module shadd_selector_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic         in_rdy;
  logic [W-1:0] opa = '0, opb = '0, opc = '0, opd = '0;
  logic         sel_first = 1'b0, sel_second = 1'b0;
  logic [W-1:0] sum_now;
  logic         out_vld;
  logic         out_rdy = 1'b1;
  logic [W-1:0] out_sum;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] sb_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shadd_selector #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy),
    .opa(opa), .opb(opb), .opc(opc), .opd(opd),
    .sel_first(sel_first), .sel_second(sel_second),
    .sum_now(sum_now), .out_vld(out_vld), .out_rdy(out_rdy),
    .out_sum(out_sum)
  );

  function automatic logic [W-1:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [W-1:0] c, logic [W-1:0] d,
                                           logic f, logic s);
    logic [W-1:0] s_ab, s_ac, s_d1;
    s_ab = a + b;
    s_ac = a + c;
    s_d1 = d + 8'd1;
    if (f)      return s_ab;
    else if (s) return s_ac;
    else        return s_d1;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic comb_check(string req);
    #1;
    check(req, sum_now, ref_sum(opa, opb, opc, opd, sel_first, sel_second));
  endtask

  // driver: offers one beat per cycle and pushes accepted results
  task automatic drive(string req, logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] c, logic [W-1:0] d, logic f, logic s);
    @(negedge clk);
    opa = a; opb = b; opc = c; opd = d;
    sel_first = f; sel_second = s;
    in_vld = 1'b1;
    comb_check(req);
    if (in_rdy) sb_q.push_back(ref_sum(a, b, c, d, f, s));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor: compares every consumed or held result against the queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && out_vld) begin
        if (sb_q.size() == 0) begin
          check("R7 spurious out_vld", 8'd1, 8'd0);
        end else if (out_rdy) begin
          check("R7 out_sum", out_sum, sb_q.pop_front());
        end else begin
          check("R8 held out_sum", out_sum, sb_q[0]);
          check("R8 in_rdy low", {7'd0, in_rdy}, 8'd0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 out_vld after reset", {7'd0, out_vld}, 8'd0);
    check("R9 out_sum after reset", out_sum, 8'd0);
    check("R7 in_rdy when empty", {7'd0, in_rdy}, 8'd1);

    // condition combinations with one operand set
    drive("R1 a+b", 8'd10, 8'd20, 8'd30, 8'd40, 1'b1, 1'b0);
    drive("R2 a+c", 8'd10, 8'd20, 8'd30, 8'd40, 1'b0, 1'b1);
    drive("R3 d+1", 8'd10, 8'd20, 8'd30, 8'd40, 1'b0, 1'b0);
    drive("R4 priority", 8'd10, 8'd20, 8'd30, 8'd40, 1'b1, 1'b1);
    // wrap cases
    drive("R5 wrap a+b", 8'd200, 8'd100, 8'd3, 8'd0, 1'b1, 1'b0);
    drive("R5 wrap a+c", 8'd255, 8'd0, 8'd1, 8'd0, 1'b0, 1'b1);
    drive("R5 wrap d+1", 8'd0, 8'd0, 8'd0, 8'd255, 1'b0, 1'b0);
    idle(3);
    check("R10 drained", {7'd0, out_vld}, 8'd0);

    // combinational follow with no edge between changes
    @(negedge clk);
    in_vld = 1'b0;
    opa = 8'd7; opb = 8'd9; opc = 8'd100; opd = 8'd50;
    sel_first = 1'b0; sel_second = 1'b1; comb_check("R6 a+c");
    sel_first = 1'b1;                     comb_check("R6 to a+b");
    sel_first = 1'b0; sel_second = 1'b0; comb_check("R6 to d+1");
    opd = 8'd128;                         comb_check("R6 operand");

    // stall: consumer not ready while beats are offered
    out_rdy = 1'b0;
    drive("R7 stall first", 8'd1, 8'd2, 8'd3, 8'd4, 1'b1, 1'b0);
    drive("R8 dropped", 8'd5, 8'd6, 8'd7, 8'd8, 1'b0, 1'b1);
    drive("R8 dropped", 8'd9, 8'd9, 8'd9, 8'd9, 1'b0, 1'b0);
    drive("R8 dropped", 8'd11, 8'd12, 8'd13, 8'd14, 1'b1, 1'b1);
    @(negedge clk);
    in_vld = 1'b0;
    out_rdy = 1'b1;
    idle(2);
    check("R10 drained after stall", {7'd0, out_vld}, 8'd0);

    // back-to-back with consumer ready
    for (int i = 0; i < 16; i++)
      drive("R1 R2 R3 stream", 8'(i * 17), 8'(i * 29 + 3), 8'(255 - i), 8'(i * 41),
            i[0], i[1]);
    idle(3);
    check("R10 final drain", {7'd0, out_vld}, 8'd0);
    check("R7 queue empty", 8'(sb_q.size()), 8'd0);

    done = 1'b1;
    finish_run();
  end
endmodule